// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is the combinational add and subtract stage of an accumulator-style integer datapath. It takes two 16-bit operands, a width select that picks byte (8-bit) or word (16-bit) arithmetic, a 3-bit operation code and the current carry flag. In the same cycle it returns the result and six status flags: carry, auxiliary carry, sign, zero, parity and overflow. For subtraction the carry and auxiliary carry report borrows, not carries.

The block has no clock and no state. The surrounding datapath keeps the carry flag. To add or subtract values wider than a word, the datapath issues a plain add (or subtract) on the low words. It then issues add-with-carry (or subtract-with-borrow) on the next words, feeding the returned carry flag back in each time. Internally, an operation decoder turns the operation code into control bits. A ripple adder handles every operation, with subtraction done by inverting the second operand. A flag generator taps the carry chain at the byte or word boundary.

Operation codes: 0 = add, 1 = add with carry, 2 = subtract, 3 = subtract with borrow, 4 = increment, 5 = decrement. Codes 6 and 7 behave as add. `word_sel` = 1 selects word arithmetic and 0 selects byte arithmetic.

Top module: `addsub_flag_unit`

## Requirements
- R1: Add (code 0, and codes 6 and 7) returns (A + B) modulo 2^n, where n is 8 or 16 according to `word_sel`. The carry flag is set when the unsigned sum exceeds 2^n - 1.
- R2: Add with carry (code 1) returns (A + B + carry_in) modulo 2^n. The carry flag is set when that unsigned sum exceeds 2^n - 1.
- R3: The overflow flag is set when the true signed result lies outside -2^(n-1) .. 2^(n-1)-1. For byte operations that range is -128..+127, and for word operations it is -32768..+32767.
- R4: Subtract (code 2) returns (A - B) modulo 2^n. Subtract with borrow (code 3) returns (A - B - carry_in) modulo 2^n. For both, the carry flag is 1 when the unsigned difference is negative, meaning a borrow occurred.
- R5: The auxiliary carry flag is the carry out of bit 3 for additions and the borrow out of bit 3 for subtractions, including the incoming carry or borrow where one is used.
- R6: The sign flag equals bit n-1 of the result. The zero flag is 1 exactly when all n result bits are 0.
- R7: The parity flag is computed over result bits 7..0 only, for both widths. It is 1 when the number of ones in those bits is even.
- R8: Increment (code 4) returns A + 1 and decrement (code 5) returns A - 1, both modulo 2^n. Operand B has no effect, and the carry flag output equals carry_in. All other flags follow R3, R5, R6 and R7.
- R9: In byte mode, result bits 15..8 are 0, and operand bits 15..8 have no effect on the result or the flags.
- R10: Byte 12h + 33h gives 45h with C=0, A=0, S=0, Z=0, P=0, O=0. Byte 22h - 44h gives DEh with C=1, A=1, S=1, Z=0, P=1, O=0.
- R11: A 32-bit sum is formed by an add on the low words followed by an add with carry on the high words, using the first carry flag as the second operation's carry_in. A 32-bit difference is formed the same way with subtract, then subtract with borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand (minuend for subtraction) |
| opnd_b | input | 16 | Second operand (subtrahend for subtraction) |
| op_code | input | 3 | Operation select, encoding as above |
| word_sel | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Sum or difference, zero-extended in byte mode |
| flag_carry | output | 1 | Carry (addition) or borrow (subtraction) out of the selected width |
| flag_aux | output | 1 | Carry or borrow out of bit 3 |
| flag_sign | output | 1 | Most significant bit of the selected width |
| flag_zero | output | 1 | Result of the selected width is zero |
| flag_parity | output | 1 | Even number of ones in result bits 7..0 |
| flag_ovf | output | 1 | Signed overflow at the selected width |

## Verification
The hardest cases to reach are those where the incoming carry alone decides a flag. Two examples: an add with carry that crosses from +127 to -128 only because of carry_in, and a subtract with borrow whose subtrahend is all ones, so that B plus the borrow equals 2^n exactly. Random operands almost never land on these points. The stimulus therefore walks a directed set of operands at the signed and unsigned edges (00, 7F, 80, FF and their word equivalents), with carry_in both 0 and 1, for every operation code and both widths. Randomised operands with random upper bytes then cover the byte-mode isolation. Chained 32-bit add and subtract sequences feed the returned carry back as the next carry_in.

// File: rtl/asu_pkg.sv
package asu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_INC  = 3'd4,
        OP_DEC  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } asu_op_e;

    typedef struct packed {
        logic subtract;    // invert B and the carry into the chain
        logic use_carry;   // fold the incoming carry flag into the operation
        logic unit_b;      // replace operand B by the constant one
        logic hold_carry;  // carry flag passes through unchanged
    } asu_ctrl_t;

endpackage

// File: rtl/asu_opdecode.sv
module asu_opdecode
    import asu_pkg::*;
(
    input  logic [2:0] op_code,
    output asu_ctrl_t  ctrl
);

    asu_op_e op;

    always_comb begin
        op = asu_op_e'(op_code);
        unique case (op)
            OP_ADD:  ctrl = '{subtract: 1'b0, use_carry: 1'b0, unit_b: 1'b0, hold_carry: 1'b0};
            OP_ADC:  ctrl = '{subtract: 1'b0, use_carry: 1'b1, unit_b: 1'b0, hold_carry: 1'b0};
            OP_SUB:  ctrl = '{subtract: 1'b1, use_carry: 1'b0, unit_b: 1'b0, hold_carry: 1'b0};
            OP_SBB:  ctrl = '{subtract: 1'b1, use_carry: 1'b1, unit_b: 1'b0, hold_carry: 1'b0};
            OP_INC:  ctrl = '{subtract: 1'b0, use_carry: 1'b0, unit_b: 1'b1, hold_carry: 1'b1};
            OP_DEC:  ctrl = '{subtract: 1'b1, use_carry: 1'b0, unit_b: 1'b1, hold_carry: 1'b1};
            OP_RSV6,
            OP_RSV7: ctrl = '{subtract: 1'b0, use_carry: 1'b0, unit_b: 1'b0, hold_carry: 1'b0};
        endcase
    end

endmodule

// File: rtl/asu_ripple.sv
module asu_ripple #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int NIBBLE_W = 4
) (
    input  logic [DATA_W-1:0] add_a,
    input  logic [DATA_W-1:0] add_b,
    input  logic              add_cin,
    output logic [DATA_W-1:0] sum,
    output logic              co_word,
    output logic              ci_word_msb,
    output logic              co_narrow,
    output logic              ci_narrow_msb,
    output logic              co_nibble
);

    logic [DATA_W:0] chain;

    assign chain[0] = add_cin;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]     = add_a[i] ^ add_b[i] ^ chain[i];
        assign chain[i+1] = (add_a[i] & add_b[i]) | (chain[i] & (add_a[i] ^ add_b[i]));
    end

    assign co_word       = chain[DATA_W];
    assign ci_word_msb   = chain[DATA_W-1];
    assign co_narrow     = chain[NARROW_W];
    assign ci_narrow_msb = chain[NARROW_W-1];
    assign co_nibble     = chain[NIBBLE_W];

endmodule

// File: rtl/asu_flaggen.sv
module asu_flaggen #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int PARITY_W = 8
) (
    input  logic [DATA_W-1:0] sum,
    input  logic              co_word,
    input  logic              ci_word_msb,
    input  logic              co_narrow,
    input  logic              ci_narrow_msb,
    input  logic              co_nibble,
    input  logic              word_sel,
    input  logic              subtract,
    input  logic              hold_carry,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_carry,
    output logic              flag_aux,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              flag_parity,
    output logic              flag_ovf
);

    localparam int UPPER_W = DATA_W - NARROW_W;

    logic chain_out;

    always_comb begin
        if (word_sel) begin
            result    = sum;
            chain_out = co_word;
            flag_ovf  = co_word ^ ci_word_msb;
            flag_sign = sum[DATA_W-1];
        end else begin
            result    = {{UPPER_W{1'b0}}, sum[NARROW_W-1:0]};
            chain_out = co_narrow;
            flag_ovf  = co_narrow ^ ci_narrow_msb;
            flag_sign = sum[NARROW_W-1];
        end
        // a subtraction's chain carries "no borrow", so invert for the flag
        flag_carry  = hold_carry ? carry_in : (chain_out ^ subtract);
        flag_aux    = co_nibble ^ subtract;
        flag_zero   = (result == '0);
        flag_parity = ~(^result[PARITY_W-1:0]);
    end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
    import asu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int NIBBLE_W = 4,
    parameter int PARITY_W = 8
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        op_code,
    input  logic              word_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_carry,
    output logic              flag_aux,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              flag_parity,
    output logic              flag_ovf
);

    localparam int UPPER_W = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    asu_ctrl_t         ctrl;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] sum;
    logic              co_word, ci_word_msb, co_narrow, ci_narrow_msb, co_nibble;

    asu_opdecode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    always_comb begin
        b_eff   = ctrl.unit_b ? ONE : opnd_b;
        add_b   = ctrl.subtract ? ~b_eff : b_eff;
        add_cin = (ctrl.use_carry & carry_in) ^ ctrl.subtract;
    end

    asu_ripple #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .NIBBLE_W (NIBBLE_W)
    ) u_add (
        .add_a         (opnd_a),
        .add_b         (add_b),
        .add_cin       (add_cin),
        .sum           (sum),
        .co_word       (co_word),
        .ci_word_msb   (ci_word_msb),
        .co_narrow     (co_narrow),
        .ci_narrow_msb (ci_narrow_msb),
        .co_nibble     (co_nibble)
    );

    asu_flaggen #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .PARITY_W (PARITY_W)
    ) u_flg (
        .sum           (sum),
        .co_word       (co_word),
        .ci_word_msb   (ci_word_msb),
        .co_narrow     (co_narrow),
        .ci_narrow_msb (ci_narrow_msb),
        .co_nibble     (co_nibble),
        .word_sel      (word_sel),
        .subtract      (ctrl.subtract),
        .hold_carry    (ctrl.hold_carry),
        .carry_in      (carry_in),
        .result        (result),
        .flag_carry    (flag_carry),
        .flag_aux      (flag_aux),
        .flag_sign     (flag_sign),
        .flag_zero     (flag_zero),
        .flag_parity   (flag_parity),
        .flag_ovf      (flag_ovf)
    );

    // Operand-to-output relations that hold for every operation
    logic [DATA_W-1:0] chk_a, chk_r;
    logic              chk_a_msb, chk_r_msb, chk_is_add, chk_is_sub, chk_is_step;

    always_comb begin
        chk_a       = word_sel ? opnd_a : {{UPPER_W{1'b0}}, opnd_a[NARROW_W-1:0]};
        chk_r       = word_sel ? result : {{UPPER_W{1'b0}}, result[NARROW_W-1:0]};
        chk_a_msb   = word_sel ? opnd_a[DATA_W-1] : opnd_a[NARROW_W-1];
        chk_r_msb   = word_sel ? result[DATA_W-1] : result[NARROW_W-1];
        chk_is_add  = (op_code == 3'd0) || (op_code == 3'd1) || (op_code[2:1] == 2'b11);
        chk_is_sub  = (op_code == 3'd2) || (op_code == 3'd3);
        chk_is_step = (op_code == 3'd4) || (op_code == 3'd5);

        // R1 / R2: a carry out of an addition means the result wrapped below A
        a_r1_add_carry_wrap: assert (!(chk_is_add && flag_carry) || (chk_r <= chk_a))
            else $error("R1: carry set but result above operand A");
        // R4: a borrow means the difference wrapped to at least A
        a_r4_sub_borrow_wrap: assert (!(chk_is_sub && flag_carry) || (chk_r >= chk_a))
            else $error("R4: borrow set but result below operand A");
        // R3: signed overflow always flips the sign relative to operand A
        a_r3_no_overflow: assert (!flag_ovf || (chk_r_msb != chk_a_msb))
            else $error("R3: overflow without sign change from operand A");
        // R6: negative and zero cannot both be reported
        a_r6_sign_zero_excl: assert (!(flag_sign && flag_zero))
            else $error("R6: sign and zero flags both set");
        // R8: increment and decrement leave the carry flag as it came in
        a_r8_carry_hold: assert (!chk_is_step || (flag_carry == carry_in))
            else $error("R8: carry flag altered by increment or decrement");
        // R9: byte mode keeps the high result byte clear
        a_r9_upper_clear: assert (word_sel || (result[DATA_W-1:NARROW_W] == '0))
            else $error("R9: high byte non-zero in byte mode");
    end

endmodule

// File: tb/sim_addsub_flag_unit.sv
module sim_addsub_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [2:0]  op_code = '0;
    logic        word_sel = 1'b0, carry_in = 1'b0;
    logic [15:0] result;
    logic        flag_carry, flag_aux, flag_sign, flag_zero, flag_parity, flag_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    addsub_flag_unit u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code), .word_sel(word_sel),
        .carry_in(carry_in), .result(result), .flag_carry(flag_carry),
        .flag_aux(flag_aux), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_parity(flag_parity), .flag_ovf(flag_ovf)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0d ws %0d a %h b %h ci %0d)",
                     tag, what, act, exp, op_code, word_sel, opnd_a, opnd_b, carry_in);
        end
    endtask

    task automatic drive(input int op, input int a, input int b, input bit ws, input bit ci);
        @(posedge clk);
        #1;
        op_code  = 3'(op);
        opnd_a   = 16'(a);
        opnd_b   = 16'(b);
        word_sel = ws;
        carry_in = ci;
        @(negedge clk);
    endtask

    // Behavioural reference: integer arithmetic on the selected width
    task automatic apply(input int op, input int a, input int b, input bit ws, input bit ci);
        int n, mask, half, ua, ub, cx, sa, sb, full, sfull, res, nib;
        bit sub, step, e_c, e_a, e_s, e_z, e_p, e_o;
        string tg;
        drive(op, a, b, ws, ci);
        n = ws ? 16 : 8;
        mask = (1 << n) - 1;
        half = 1 << (n - 1);
        ua = a & mask;
        ub = b & mask;
        cx = 0;
        sub = 0;
        step = 0;
        case (op)
            1: cx = ci;
            2: sub = 1;
            3: begin sub = 1; cx = ci; end
            4: begin ub = 1; step = 1; end
            5: begin ub = 1; step = 1; sub = 1; end
            default: ;
        endcase
        sa = (ua >= half) ? ua - (1 << n) : ua;
        sb = (ub >= half) ? ub - (1 << n) : ub;
        if (sub) begin
            full  = ua - ub - cx;
            sfull = sa - sb - cx;
            e_c   = full < 0;
            nib   = (ua & 15) - (ub & 15) - cx;
            e_a   = nib < 0;
        end else begin
            full  = ua + ub + cx;
            sfull = sa + sb + cx;
            e_c   = full > mask;
            nib   = (ua & 15) + (ub & 15) + cx;
            e_a   = nib > 15;
        end
        if (step) e_c = ci;
        res = full & mask;
        e_o = (sfull > half - 1) || (sfull < -half);
        e_z = (res == 0);
        e_s = ((res >> (n - 1)) & 1) != 0;
        e_p = ($countones(res & 255) % 2) == 0;
        tg = step ? "R8" : (op == 1) ? "R2" : sub ? "R4" : "R1";
        check(tg, "result", int'(result), res);
        check(tg, "carry", int'(flag_carry), int'(e_c));
        check("R5", "aux", int'(flag_aux), int'(e_a));
        check("R6", "sign", int'(flag_sign), int'(e_s));
        check("R6", "zero", int'(flag_zero), int'(e_z));
        check("R7", "parity", int'(flag_parity), int'(e_p));
        check("R3", "overflow", int'(flag_ovf), int'(e_o));
        if (!ws) check("R9", "high byte", int'(result[15:8]), 0);
    endtask

    task automatic chain32(input bit do_sub, input int x, input int y);
        int lo, hi, got, want;
        bit c;
        drive(do_sub ? 2 : 0, x & 16'hFFFF, y & 16'hFFFF, 1'b1, 1'b0);
        lo = int'(result);
        c = flag_carry;
        drive(do_sub ? 3 : 1, (x >>> 16) & 16'hFFFF, (y >>> 16) & 16'hFFFF, 1'b1, c);
        hi = int'(result);
        got = (hi << 16) | lo;
        want = do_sub ? x - y : x + y;
        check("R11", do_sub ? "32-bit difference" : "32-bit sum", got, want);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int edges[8];
        edges = '{0, 1, 'h0F, 'h7F, 'h80, 'hFF, 'h7FFF, 'h8000};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle inputs: ADD of zeros
        check("R6", "idle zero flag", int'(flag_zero), 1);
        check("R7", "idle parity", int'(flag_parity), 1);
        check("R1", "idle result", int'(result), 0);

        // R10 worked examples
        drive(0, 'h12, 'h33, 1'b0, 1'b0);
        check("R10", "12+33 result", int'(result), 'h45);
        check("R10", "12+33 flags CASZPO",
              int'({flag_carry, flag_aux, flag_sign, flag_zero, flag_parity, flag_ovf}), 0);
        drive(2, 'h22, 'h44, 1'b0, 1'b0);
        check("R10", "22-44 result", int'(result), 'hDE);
        check("R10", "22-44 flags CASZPO",
              int'({flag_carry, flag_aux, flag_sign, flag_zero, flag_parity, flag_ovf}), 'b111010);

        // boundary sweep: every op, both widths, both carries, edge operands
        for (int op = 0; op < 8; op++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++)
                            apply(op, edges[i] | (w ? 0 : 'hA500), edges[j] | 'hFF00 * (j % 2),
                                  w[0], c[0]);

        // random operands, including random upper bytes in byte mode (R9)
        for (int k = 0; k < 3000; k++)
            apply(int'($urandom_range(7, 0)), int'($urandom_range(16'hFFFF, 0)),
                  int'($urandom_range(16'hFFFF, 0)), 1'($urandom_range(1, 0)),
                  1'($urandom_range(1, 0)));

        // multiword chaining R11
        chain32(1'b0, 32'h0001_FFFF, 32'h0000_0001);
        chain32(1'b0, 32'h7FFF_8000, 32'h0000_9000);
        chain32(1'b1, 32'h0001_0000, 32'h0000_0001);
        chain32(1'b1, 32'h1234_0000, 32'h0234_5678);
        for (int k = 0; k < 200; k++)
            chain32(1'($urandom_range(1, 0)), int'($urandom), int'($urandom));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule